// File: doc/BRIEF.md
# Branch Target Buffer with Direction Filters and Return Stack

This block sits next to a processor's fetch stage and guesses where the next fetch should go. It holds a small set of branch records. Each record stores the branch's own address, its most recent taken target and a two-bit confidence counter. Every record is compared against the current fetch address in parallel, and the result comes back in the same cycle: a hit flag, a predicted-taken flag and a target address. When a branch resolves later in the pipeline, the update stream either trains the matching record or claims a slot for a new taken branch.

Software controls the block through a six-bit control register. One bit is a write-one flush command that empties the buffer. A second bit turns prediction on, and it is off after reset. Two two-bit selectors choose which branch directions may be predicted and which may be allocated. A branch counts as backward when its target is numerically below its own address. A separate four-deep return-address stack handles subroutine returns. A call pushes the return address and a return pops it. When the stack overflows, the oldest entry is overwritten.

The lookup result needs no handshake. `pred_valid` simply follows `fetch_valid` in the same cycle. The update stream uses valid/ready. `upd_ready` drops only in a cycle that carries a flush write. The source must then hold its update and present it again in a later cycle. An update counts as accepted only in a cycle where `upd_valid` and `upd_ready` are both high.

Top module: `brpred_unit`

## Requirements
- R1: After reset, `ctl_rdata` reads 0, prediction is disabled and no lookup reports a hit.
- R2: While the enable bit (`ctl_wdata` bit 1) is 0, lookups report no hit and accepted updates allocate nothing. An update made while disabled is not visible after enabling.
- R3: Writing 1 to bit 0 of the control register invalidates every entry by the next cycle. Bit 0 always reads back 0. A lookup in the same cycle as the flush write reports no hit, and `upd_ready` is 0 in that cycle.
- R4: The control register reads back as {alloc_sel[5:4], pred_sel[3:2], enable[1], 0} one cycle after a write.
- R5: An accepted taken update that hits no valid entry and passes the allocation selector creates an entry whose counter starts at 2 (predict taken). A not-taken update that misses creates nothing.
- R6: The allocation selector (bits 5:4) uses this encoding: 00 allows both directions, 01 allows backward only, 10 allows forward only, 11 allows neither.
- R7: The prediction selector (bits 3:2) uses the same encoding. A hit on a stored branch whose direction is not allowed is reported as no hit.
- R8: Any entry can hold any branch. A lookup that matches a valid entry returns that entry's target from the cycle after the update. A taken update that hits an entry replaces its target.
- R9: Each entry has a two-bit saturating counter. A taken update increments it, up to a maximum of 3. A not-taken update decrements it, down to a minimum of 0. `pred_taken` is the counter's top bit on a hit.
- R10: An allocation uses a free slot while one exists. When the buffer is full, it evicts the slot under a round-robin pointer. The pointer starts at slot 0 after reset or flush and advances by one after each eviction.
- R11: The return stack is last-in first-out. `ret_pred_valid` is 0 when the stack is empty, and a pop on an empty stack changes nothing.
- R12: A push onto a full return stack overwrites the oldest entry, so only the last four pushes remain available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data: flush, enable, pred_sel, alloc_sel |
| ctl_rdata | output | 6 | Control register read value |
| fetch_valid | input | 1 | Lookup request present |
| fetch_pc | input | AW | Fetch address to look up |
| pred_valid | output | 1 | Lookup result present (same cycle) |
| pred_hit | output | 1 | A permitted valid entry matched |
| pred_taken | output | 1 | Predicted taken (hit and counter top bit set) |
| pred_target | output | AW | Predicted target, 0 on a miss |
| upd_valid | input | 1 | Resolved branch update present |
| upd_ready | output | 1 | Update accepted this cycle (low during a flush write) |
| upd_pc | input | AW | Address of the resolved branch |
| upd_target | input | AW | Resolved target address |
| upd_taken | input | 1 | Resolved direction |
| call_push | input | 1 | Push a return address |
| call_ret_addr | input | AW | Return address to push |
| ret_pop | input | 1 | Pop the return stack |
| ret_pred_valid | output | 1 | Return stack is not empty |
| ret_pred_addr | output | AW | Address on top of the return stack |

## Verification
Lookup results and `upd_ready` are combinational, so they are due in the same cycle as the fetch address or flush write. The bench drives these inputs just after a rising edge and samples the outputs a nanosecond later, before the next edge. Control writes, updates, pushes and pops take effect at the next rising edge. Each of those stimuli is therefore held for one edge, and its effect is sampled only after that edge. Expected hit, target and taken values come from an arithmetic model in the bench: the selector encoding, a counter that saturates at 0 and 3, and eviction order by slot number.

// File: rtl/brpred_pkg.sv
package brpred_pkg;
  localparam int CTL_W = 6;
  localparam logic [1:0] SEL_BOTH = 2'b00;
  localparam logic [1:0] SEL_BACK = 2'b01;
  localparam logic [1:0] SEL_FWD  = 2'b10;
  localparam logic [1:0] CTR_INIT = 2'b10;

  function automatic logic sel_permits(input logic [1:0] sel, input logic backward);
    case (sel)
      SEL_BOTH: return 1'b1;
      SEL_BACK: return backward;
      SEL_FWD:  return !backward;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/brpred_dir_filter.sv
module brpred_dir_filter #(
  parameter int AW = 32
) (
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] br_pc_i,
  input  logic [AW-1:0] br_target_i,
  output logic          permit_o
);
  import brpred_pkg::*;
  logic backward;
  assign backward = br_target_i < br_pc_i;
  assign permit_o = sel_permits(sel_i, backward);
endmodule

// File: rtl/brpred_entry_array.sv
module brpred_entry_array #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] lk_pc_i,
  output logic          lk_hit_o,
  output logic [AW-1:0] lk_target_o,
  output logic [1:0]    lk_ctr_o,
  input  logic          up_fire_i,
  input  logic [AW-1:0] up_pc_i,
  input  logic [AW-1:0] up_target_i,
  input  logic          up_taken_i,
  input  logic          up_alloc_ok_i
);
  import brpred_pkg::*;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [AW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] lk_match, up_match;
  logic               up_hit, has_free, do_alloc;
  logic [IW-1:0]      free_idx, alloc_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = vld_q[i] && (tag_q[i] == lk_pc_i);
    assign up_match[i] = vld_q[i] && (tag_q[i] == up_pc_i);
  end

  always_comb begin
    lk_target_o = '0;
    lk_ctr_o    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_target_o = tgt_q[i];
        lk_ctr_o    = ctr_q[i];
      end
    end
  end
  assign lk_hit_o = |lk_match;

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        has_free = 1'b1;
      end
    end
  end

  assign up_hit    = |up_match;
  assign alloc_idx = has_free ? free_idx : rr_q;
  assign do_alloc  = up_fire_i && !up_hit && up_taken_i && up_alloc_ok_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      if (up_fire_i && up_hit) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (up_match[i]) begin
            ctr_q[i] <= ctr_next(ctr_q[i], up_taken_i);
            if (up_taken_i) tgt_q[i] <= up_target_i;
          end
        end
      end
      if (do_alloc) begin
        vld_q[alloc_idx] <= 1'b1;
        tag_q[alloc_idx] <= up_pc_i;
        tgt_q[alloc_idx] <= up_target_i;
        ctr_q[alloc_idx] <= CTR_INIT;
        if (!has_free) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0)); // R3
  AST_ALLOC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !flush_i) |=> vld_q[$past(alloc_idx)]); // R5
  AST_NOTTAKEN_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire_i && !up_taken_i && !up_hit && !flush_i) |=> $stable(vld_q)); // R5
  AST_RR_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (has_free && !flush_i) |=> $stable(rr_q)); // R10
endmodule

// File: rtl/brpred_ret_stack.sv
module brpred_ret_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic          top_valid_o,
  output logic [AW-1:0] top_addr_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q, top_idx, ptr_inc;
  logic [CW-1:0] cnt_q;

  assign ptr_inc     = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign top_idx     = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;
  assign top_valid_o = (cnt_q != '0);
  assign top_addr_o  = top_valid_o ? mem_q[top_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i && pop_i && top_valid_o) begin
      mem_q[top_idx] <= push_addr_i;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_addr_i;
      ptr_q        <= ptr_inc;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && top_valid_o) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R12
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !top_valid_o) |=> !top_valid_o); // R11
  AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !flush_i) |=> (top_valid_o && top_addr_o == $past(push_addr_i))); // R11
endmodule

// File: rtl/brpred_unit.sv
module brpred_unit #(
  parameter int ENTRIES   = 8,
  parameter int RAS_DEPTH = 4,
  parameter int AW        = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_we,
  input  logic [brpred_pkg::CTL_W-1:0] ctl_wdata,
  output logic [brpred_pkg::CTL_W-1:0] ctl_rdata,
  input  logic                      fetch_valid,
  input  logic [AW-1:0]             fetch_pc,
  output logic                      pred_valid,
  output logic                      pred_hit,
  output logic                      pred_taken,
  output logic [AW-1:0]             pred_target,
  input  logic                      upd_valid,
  output logic                      upd_ready,
  input  logic [AW-1:0]             upd_pc,
  input  logic [AW-1:0]             upd_target,
  input  logic                      upd_taken,
  input  logic                      call_push,
  input  logic [AW-1:0]             call_ret_addr,
  input  logic                      ret_pop,
  output logic                      ret_pred_valid,
  output logic [AW-1:0]             ret_pred_addr
);
  import brpred_pkg::*;

  logic       en_q;
  logic [1:0] pred_sel_q, alloc_sel_q;
  logic       flush_now, upd_fire;
  logic       arr_hit, pred_ok, alloc_ok;
  logic [AW-1:0] arr_target;
  logic [1:0]    arr_ctr;

  assign flush_now = ctl_we && ctl_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      pred_sel_q  <= 2'b00;
      alloc_sel_q <= 2'b00;
    end else if (ctl_we) begin
      en_q        <= ctl_wdata[1];
      pred_sel_q  <= ctl_wdata[3:2];
      alloc_sel_q <= ctl_wdata[5:4];
    end
  end
  assign ctl_rdata = {alloc_sel_q, pred_sel_q, en_q, 1'b0};

  assign upd_ready = !flush_now;
  assign upd_fire  = upd_valid && upd_ready && en_q;

  brpred_dir_filter #(.AW(AW)) u_pred_filter (
    .sel_i(pred_sel_q), .br_pc_i(fetch_pc), .br_target_i(arr_target), .permit_o(pred_ok));

  brpred_dir_filter #(.AW(AW)) u_alloc_filter (
    .sel_i(alloc_sel_q), .br_pc_i(upd_pc), .br_target_i(upd_target), .permit_o(alloc_ok));

  brpred_entry_array #(.ENTRIES(ENTRIES), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_now),
    .lk_pc_i(fetch_pc), .lk_hit_o(arr_hit), .lk_target_o(arr_target), .lk_ctr_o(arr_ctr),
    .up_fire_i(upd_fire), .up_pc_i(upd_pc), .up_target_i(upd_target),
    .up_taken_i(upd_taken), .up_alloc_ok_i(alloc_ok));

  brpred_ret_stack #(.DEPTH(RAS_DEPTH), .AW(AW)) u_ras (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_now),
    .push_i(call_push), .push_addr_i(call_ret_addr), .pop_i(ret_pop),
    .top_valid_o(ret_pred_valid), .top_addr_o(ret_pred_addr));

  assign pred_valid  = fetch_valid;
  assign pred_hit    = fetch_valid && en_q && !flush_now && arr_hit && pred_ok;
  assign pred_taken  = pred_hit && arr_ctr[1];
  assign pred_target = pred_hit ? arr_target : '0;

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pred_hit); // R2
  AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] == 1'b0); // R3
  AST_FLUSH_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |-> (!pred_hit && !upd_ready)); // R3
  AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[5:1] == $past(ctl_wdata[5:1]))); // R4
  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit); // R9
endmodule

// File: tb/tb_brpred_unit.sv
module tb_brpred_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_rdata;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic pred_valid, pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic upd_taken = 1'b0;
  logic call_push = 1'b0, ret_pop = 1'b0;
  logic [31:0] call_ret_addr = '0;
  logic ret_pred_valid;
  logic [31:0] ret_pred_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brpred_unit dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .pred_valid(pred_valid),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken),
    .call_push(call_push), .call_ret_addr(call_ret_addr), .ret_pop(ret_pop),
    .ret_pred_valid(ret_pred_valid), .ret_pred_addr(ret_pred_addr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl_write(input logic [5:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    tick();
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input logic tk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tg; upd_taken = tk;
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, output logic h, output logic t, output logic [31:0] tg);
    fetch_valid = 1'b1; fetch_pc = pc;
    #1;
    h = pred_hit; t = pred_taken; tg = pred_target;
    fetch_valid = 1'b0;
  endtask

  task automatic push(input logic [31:0] a);
    call_push = 1'b1; call_ret_addr = a;
    tick();
    call_push = 1'b0;
  endtask

  task automatic pop();
    ret_pop = 1'b1;
    tick();
    ret_pop = 1'b0;
  endtask

  function automatic logic permits(input int sel, input int back);
    return (sel == 0) || (sel == 1 && back == 1) || (sel == 2 && back == 0);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic h, t;
    logic [31:0] tg;
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 ctl_rdata", 32'(ctl_rdata), 32'h0);
    look(32'h100, h, t, tg);
    check("R1 no hit after reset", 32'(h), 0);

    // R2 disabled: update ignored, still not there after enable
    check("R2 upd_ready while idle", 32'(upd_ready), 1);
    upd(32'h100, 32'h200, 1'b1);
    look(32'h100, h, t, tg);
    check("R2 disabled lookup", 32'(h), 0);
    ctl_write(6'h02);
    check("R4 readback enable", 32'(ctl_rdata), 32'h02);
    look(32'h100, h, t, tg);
    check("R2 no allocation while disabled", 32'(h), 0);

    // R6 allocation selector sweep
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 2; d++) begin
        logic [31:0] pc, tgt;
        ctl_write(6'(6'h03 | (a << 4)));
        check("R3 R4 flush bit reads 0", 32'(ctl_rdata), 32'(6'h02 | (a << 4)));
        pc  = 32'h400 + 32'(a) * 32'h100 + 32'(d) * 32'h40;
        tgt = (d == 1) ? pc - 32'h20 : pc + 32'h20;
        upd(pc, tgt, 1'b1);
        look(pc, h, t, tg);
        check("R6 alloc selector", 32'(h), 32'(permits(a, d)));
      end
    end

    // R7 prediction selector sweep
    for (int p = 0; p < 4; p++) begin
      ctl_write(6'(6'h03 | (p << 2)));
      upd(32'h800, 32'h900, 1'b1);
      upd(32'h880, 32'h700, 1'b1);
      look(32'h800, h, t, tg);
      check("R7 pred selector forward", 32'(h), 32'(permits(p, 0)));
      look(32'h880, h, t, tg);
      check("R7 pred selector backward", 32'(h), 32'(permits(p, 1)));
    end

    // R8 R10 fill all eight slots
    ctl_write(6'h03);
    look(32'h800, h, t, tg);
    check("R3 flush invalidates", 32'(h), 0);
    for (int i = 0; i < 8; i++) upd(32'h1000 + 32'(i) * 16, 32'h3000 + 32'(i) * 16, 1'b1);
    for (int i = 0; i < 8; i++) begin
      look(32'h1000 + 32'(i) * 16, h, t, tg);
      check("R8 R10 hit in filled slot", 32'(h), 1);
      check("R8 target", tg, 32'h3000 + 32'(i) * 16);
      check("R5 initial counter predicts taken", 32'(t), 1);
    end
    upd(32'h5000, 32'h5100, 1'b0);
    look(32'h5000, h, t, tg);
    check("R5 not-taken miss no alloc", 32'(h), 0);
    upd(32'h6000, 32'h6100, 1'b1);
    look(32'h1000, h, t, tg);
    check("R10 slot 0 evicted first", 32'(h), 0);
    look(32'h6000, h, t, tg);
    check("R10 new entry target", tg, 32'h6100);
    look(32'h1010, h, t, tg);
    check("R10 slot 1 kept", 32'(h), 1);
    upd(32'h6010, 32'h6110, 1'b1);
    look(32'h1010, h, t, tg);
    check("R10 pointer advanced to slot 1", 32'(h), 0);
    look(32'h1020, h, t, tg);
    check("R10 slot 2 kept", 32'(h), 1);

    // R9 counter sweep on 0x1020
    c = 2;
    for (int s = 0; s < 8; s++) begin
      logic tk;
      tk = (s >= 3 && s <= 6) ? 1'b1 : 1'b0;
      c = tk ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
      upd(32'h1020, 32'h3020, tk);
      look(32'h1020, h, t, tg);
      check("R9 counter hit", 32'(h), 1);
      check("R9 counter top bit", 32'(t), 32'(c >= 2));
    end
    upd(32'h1020, 32'h7770, 1'b1);
    look(32'h1020, h, t, tg);
    check("R8 target replaced", tg, 32'h7770);

    // R3 flush in same cycle as a lookup
    look(32'h1040, h, t, tg);
    check("R3 hit before flush", 32'(h), 1);
    ctl_we = 1'b1; ctl_wdata = 6'h03; fetch_valid = 1'b1; fetch_pc = 32'h1040;
    #1;
    check("R3 flush cycle miss", 32'(pred_hit), 0);
    check("R3 upd_ready low on flush", 32'(upd_ready), 0);
    tick();
    ctl_we = 1'b0; ctl_wdata = '0; fetch_valid = 1'b0;
    look(32'h1040, h, t, tg);
    check("R3 miss after flush", 32'(h), 0);
    check("R3 upd_ready back high", 32'(upd_ready), 1);

    // R11 return stack order and empty pop
    check("R11 empty after flush", 32'(ret_pred_valid), 0);
    push(32'hA0); push(32'hA4); push(32'hA8);
    for (int k = 2; k >= 0; k--) begin
      check("R11 top valid", 32'(ret_pred_valid), 1);
      check("R11 LIFO order", ret_pred_addr, 32'hA0 + 32'(k) * 4);
      pop();
    end
    check("R11 empty", 32'(ret_pred_valid), 0);
    pop();
    check("R11 pop on empty", 32'(ret_pred_valid), 0);

    // R12 overflow keeps last four
    for (int k = 0; k < 6; k++) push(32'hB0 + 32'(k) * 4);
    for (int k = 5; k >= 2; k--) begin
      check("R12 wrap order", ret_pred_addr, 32'hB0 + 32'(k) * 4);
      pop();
    end
    check("R12 oldest overwritten", 32'(ret_pred_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule